// File: doc/BRIEF.md
# Configurable Processor Register Port

This block lets an embedded processor read and write a small bank of 8-bit registers addressed by six bits. The processor presents an active-low chip select, a direction pin, an address and write data; the port answers with read data and an active-low ready. The pads are modelled as data and enable pairs. `dataOut`/`dataOe` stand for the bidirectional data pins and `rdyOut`/`rdyOe` for the ready pin, where a low enable means the pin floats.

Two static mode pins set the access style. `modeSel[1]` chooses between two cycle types. One is a fixed cycle of exactly five clocks, suited to processors that pulse chip select and wait for a one-clock ready. The other is a variable cycle that lasts as long as chip select stays low, suited to processors that hold the strobe until they see ready. `modeSel[0]` sets which level of the direction pin means "write". The block takes in the address and write data, and updates the register once per completed access. It also decides, clock by clock, when the data bus and ready are driven.

Top module: `cpu_reg_port`

## Requirements
- R1: Out of reset and between accesses, `dataOe` is 0. `rdyOe` is 0 when `modeSel[1]`=0, and `rdyOe`=1 with `rdyOut`=1 when `modeSel[1]`=1.
- R2: With `modeSel[1]`=0, an access starts at the edge where `csN` is sampled low while idle. Call the clock after that edge clock 1. In clocks 1 to 4, `rdyOe`=1 and `rdyOut`=1. In clock 5, `rdyOe`=1 and `rdyOut`=0. At all other times `rdyOe`=0.
- R3: On a read, `dataOut` carries the register at the address sampled at the start edge. The bus is driven in clock 5 in fixed mode, and from clock 5 onward while `csN` stays low in variable mode. Writes never drive the bus. Register a resets to (37·a+5) mod 256.
- R4: Write data is sampled at the edge that ends clock 1. In fixed mode the access runs all five clocks, whatever `csN` does after the start edge.
- R5: In fixed mode, if `csN` is sampled low at the edge ending clock 5, the next access starts at that edge, with no idle clock.
- R6: With `modeSel[1]`=1, ready is always driven. `rdyOut`=1 in clocks 1 to 4, and `rdyOut`=0 from clock 5 for as long as `csN` remains low.
- R7: In variable mode, in the clock in which `csN` rises after clock 5, `dataOe` falls to 0 and `rdyOut` returns to 1 without waiting for an edge.
- R8: In variable mode, after an access ends, a low `csN` is not taken as a new start until `csN` has been sampled high on two edges.
- R9: `modeSel[0]`=1 makes `dirIn`=0 mean write. `modeSel[0]`=0 makes `dirIn`=1 mean write. The other level means read.
- R10: A completed write updates the addressed register exactly once, at the edge ending clock 5. Later reads return the new value.
- R11: In variable mode, if `csN` is sampled high at any edge ending clocks 1 to 4, the access is dropped. No register changes, the bus is not driven and ready stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Bit 1: variable-length cycle; bit 0: direction pin is an active-low write |
| csN | input | 1 | Active-low chip select |
| dirIn | input | 1 | Direction pin, polarity per `modeSel[0]` |
| addrIn | input | 6 | Register address |
| dataIn | input | 8 | Write data from the processor |
| dataOut | output | 8 | Read data toward the processor |
| dataOe | output | 1 | Data pin drive enable |
| rdyOut | output | 1 | Active-low ready level |
| rdyOe | output | 1 | Ready pin drive enable |

## Verification
The hardest case to reach is the recovery window in variable mode. A processor that raises chip select for a single edge and then lowers it again should see its next access start one clock late, not get a truncated or merged access. The stimulus ends a read, raises `csN` for exactly one sampled edge, and lowers it again during the recovery clock. It then counts the clocks until read data is driven, and that count must be six, not five. Aborts are reached by raising `csN` after each of the first four clocks in turn, followed by read-backs. Back-to-back fixed accesses are reached by lowering `csN` again during clock 5 of the previous access.

// File: rtl/regport_pkg.sv
package regport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_HOLD,
    ST_GAP
  } portState_e;

  typedef struct packed {
    logic capAddr;   // take address and direction
    logic capData;   // take write data
    logic wrStb;     // commit write to register bank
    logic driveBus;  // present read data on the pins
  } portStrobe_t;

endpackage

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
#(
  parameter int ACC_LEN = 5,
  parameter int GAP_LEN = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  input  logic        csN,
  input  logic        dirIn,
  output portStrobe_t strobes,
  output logic        rdyOut,
  output logic        rdyOe
);

  localparam int CNT_W = $clog2(ACC_LEN + 1);
  localparam int GAP_W = $clog2(GAP_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_PH  = CNT_W'(ACC_LEN);
  localparam logic [CNT_W-1:0] FIRST_PH = CNT_W'(1);
  localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(GAP_LEN - 1);
  localparam portState_e END_STATE = (GAP_LEN > 1) ? ST_GAP : ST_IDLE;

  portState_e       stateQ, stateD;
  logic [CNT_W-1:0] phaseQ, phaseD;
  logic [GAP_W-1:0] gapQ, gapD;
  logic             isWrQ, isWrD;

  logic varMode, wrLevel, inAct, lastPh, showPh, startIdle, chainStart;

  assign varMode    = modeSel[1];
  assign wrLevel    = modeSel[0] ? ~dirIn : dirIn;
  assign inAct      = (stateQ == ST_ACT);
  assign lastPh     = inAct && (phaseQ == LAST_PH);
  assign showPh     = lastPh || (stateQ == ST_HOLD);
  assign startIdle  = (stateQ == ST_IDLE) && !csN;
  assign chainStart = lastPh && !varMode && !csN;

  always_comb begin
    stateD = stateQ;
    phaseD = phaseQ;
    gapD   = gapQ;
    isWrD  = isWrQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (!csN) begin
          stateD = ST_ACT;
          phaseD = FIRST_PH;
          isWrD  = wrLevel;
        end
      end
      ST_ACT: begin
        if (!lastPh) begin
          if (varMode && csN) begin
            stateD = END_STATE;
            gapD   = GAP_W'(1);
          end else begin
            phaseD = phaseQ + FIRST_PH;
          end
        end else if (varMode) begin
          if (csN) begin
            stateD = END_STATE;
            gapD   = GAP_W'(1);
          end else begin
            stateD = ST_HOLD;
          end
        end else if (!csN) begin
          phaseD = FIRST_PH;
          isWrD  = wrLevel;
        end else begin
          stateD = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (csN) begin
          stateD = END_STATE;
          gapD   = GAP_W'(1);
        end
      end
      ST_GAP: begin
        if (gapQ >= GAP_END) stateD = ST_IDLE;
        else                 gapD   = gapQ + GAP_W'(1);
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= '0;
      gapQ   <= '0;
      isWrQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
      gapQ   <= gapD;
      isWrQ  <= isWrD;
    end
  end

  always_comb begin
    strobes.capAddr  = startIdle || chainStart;
    strobes.capData  = inAct && (phaseQ == FIRST_PH) && isWrQ;
    strobes.wrStb    = lastPh && isWrQ;
    strobes.driveBus = showPh && !isWrQ && !(varMode && csN);
  end

  assign rdyOe  = varMode || inAct;
  assign rdyOut = varMode ? !(showPh && !csN) : !lastPh;

  // R10: a commit never repeats on the following clock
  a_r10_single_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStb |=> !strobes.wrStb);

  // R4: data capture always follows an address capture by one clock
  a_r4_data_after_addr: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capData |-> $past(strobes.capAddr));

  // R2: fixed-mode ready low lasts a single clock
  a_r2_rdy_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel[1] && rdyOe && !rdyOut) |=> !(rdyOe && !rdyOut && inAct && phaseQ == LAST_PH));

  // R11: chip select seen high early in a variable access prevents the commit
  a_r11_abort_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (inAct && !lastPh && modeSel[1] && csN) |=> !strobes.wrStb);

  // R5: fixed mode chains into a fresh first clock
  a_r5_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (lastPh && !modeSel[1] && !csN) |=> (inAct && phaseQ == FIRST_PH));

  // R8: the recovery clock never starts an access directly
  a_r8_gap_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_GAP) |=> (stateQ != ST_ACT));

endmodule

// File: rtl/regport_datapath.sv
module regport_datapath
  import regport_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrDataQ <= '0;
    end else begin
      if (strobes.capAddr) addrQ   <= addrIn;
      if (strobes.capData) wrDataQ <= dataIn;
    end
  end

  assign regAddr   = addrQ;
  assign regWrEn   = strobes.wrStb;
  assign regWrData = wrDataQ;
  assign dataOe    = strobes.driveBus;
  assign dataOut   = strobes.driveBus ? regRdData : '0;

  // R3: read data held on the bus does not move while it stays driven
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.driveBus && $past(strobes.driveBus)) |-> $stable(dataOut));

  // R10: the target address does not shift on the commit clock
  a_r10_addr_steady: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStb |-> $stable(addrQ));

endmodule

// File: rtl/regport_regs.sv
module regport_regs #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cellBus [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] cellQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   cellQ <= DATA_W'(g * 37 + 5);
      else if (wrEn && (addr == ADDR_W'(g)))       cellQ <= wrData;
    end
    assign cellBus[g] = cellQ;
  end

  assign rdData = cellBus[addr];

endmodule

// File: rtl/cpu_reg_port.sv
module cpu_reg_port
  import regport_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int ACC_LEN = 5,
  parameter int GAP_LEN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              csN,
  input  logic              dirIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              rdyOut,
  output logic              rdyOe
);

  portStrobe_t       strobes;
  logic [ADDR_W-1:0] regAddr;
  logic              regWrEn;
  logic [DATA_W-1:0] regWrData;
  logic [DATA_W-1:0] regRdData;

  regport_ctrl #(.ACC_LEN(ACC_LEN), .GAP_LEN(GAP_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .dirIn(dirIn),
    .strobes(strobes), .rdyOut(rdyOut), .rdyOe(rdyOe)
  );

  regport_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrIn(addrIn), .dataIn(dataIn),
    .regRdData(regRdData), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .dataOut(dataOut), .dataOe(dataOe)
  );

  regport_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rstN(rstN), .addr(regAddr), .wrEn(regWrEn),
    .wrData(regWrData), .rdData(regRdData)
  );

endmodule

// File: tb/test_cpu_reg_port.sv
module test_cpu_reg_port;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] modeSel;
  logic       csN, dirIn;
  logic [5:0] addrIn;
  logic [7:0] dataIn, dataOut;
  logic       dataOe, rdyOut, rdyOe;

  int checks = 0;
  int errors = 0;
  logic [7:0] expMem [64];

  always #5 clk = ~clk;

  cpu_reg_port i_cpu_reg_port (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .dirIn(dirIn),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .rdyOut(rdyOut), .rdyOe(rdyOe)
  );

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic logic dirFor(input bit wr);
    return modeSel[0] ? !wr : wr;
  endfunction

  // Entered just after a negedge (or just after the start edge when chainIn).
  task automatic fixedAcc(input bit wr, input logic [5:0] a, input logic [7:0] d,
                          input bit chainIn, input bit chainOut,
                          input bit wrN, input logic [5:0] aN, input logic [7:0] dN,
                          input string rtag);
    string tag;
    tag = chainIn ? "R5" : "R2";
    if (!chainIn) begin
      csN = 1'b0; addrIn = a; dirIn = dirFor(wr); dataIn = ~d;
      #4;
      chk(rdyOe === 1'b0 && dataOe === 1'b0, "R2 pins float before start",
          int'({rdyOe, dataOe}), 0);
      @(posedge clk);
    end
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 1) begin csN = 1'b1; dataIn = d; end
      if (k == 2) dataIn = ~d;
      if (k == 5 && chainOut) begin
        csN = 1'b0; addrIn = aN; dirIn = dirFor(wrN); dataIn = ~dN;
      end
      #4;
      chk(rdyOe === 1'b1 && rdyOut === (k != 5), {tag, " fixed ready pattern"},
          int'({rdyOe, rdyOut}), int'({1'b1, k != 5}));
      chk(dataOe === (!wr && k == 5), "R3 fixed bus drive window",
          int'(dataOe), int'(!wr && k == 5));
      if (!wr && k == 5)
        chk(dataOut === expMem[a], {rtag, " fixed read data"}, int'(dataOut), int'(expMem[a]));
      @(posedge clk);
    end
    if (wr) expMem[a] = d;
    if (!chainOut) begin
      @(negedge clk);
      #4;
      chk(rdyOe === 1'b0 && dataOe === 1'b0, "R2 pins float after access",
          int'({rdyOe, dataOe}), 0);
      @(negedge clk);
    end
  endtask

  // Entered just after a negedge; csN is low for the start clock and phases 1..lowPh.
  task automatic varAcc(input bit wr, input logic [5:0] a, input logic [7:0] d,
                        input int lowPh, input string rtag);
    csN = 1'b0; addrIn = a; dirIn = dirFor(wr); dataIn = d;
    #4;
    chk(rdyOe === 1'b1 && rdyOut === 1'b1 && dataOe === 1'b0, "R1 variable idle ready high",
        int'({rdyOe, rdyOut, dataOe}), 6);
    @(posedge clk);
    for (int k = 1; k <= lowPh + 1; k++) begin
      @(negedge clk);
      if (k == lowPh + 1) csN = 1'b1;
      #4;
      if (k <= lowPh) begin
        chk(rdyOe === 1'b1 && rdyOut === (k < 5), "R6 variable ready level",
            int'({rdyOe, rdyOut}), int'({1'b1, k < 5}));
        chk(dataOe === (!wr && k >= 5), "R3 variable bus drive window",
            int'(dataOe), int'(!wr && k >= 5));
        if (!wr && k >= 5)
          chk(dataOut === expMem[a], {rtag, " variable read data"}, int'(dataOut), int'(expMem[a]));
      end else begin
        chk(rdyOe === 1'b1 && rdyOut === 1'b1 && dataOe === 1'b0,
            (lowPh < 4) ? "R11 abort keeps ready high" : "R7 release on chip select rise",
            int'({rdyOe, rdyOut, dataOe}), 6);
      end
      @(posedge clk);
    end
    if (wr && lowPh >= 4) expMem[a] = d;
    @(negedge clk);
    #4;
    chk(rdyOe === 1'b1 && rdyOut === 1'b1 && dataOe === 1'b0, "R6 ready driven in recovery",
        int'({rdyOe, rdyOut, dataOe}), 6);
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; csN = 1'b1; dirIn = 1'b0; addrIn = '0; dataIn = '0; modeSel = 2'b00;
    for (int i = 0; i < 64; i++) expMem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #4;
    chk(rdyOe === 1'b0 && dataOe === 1'b0, "R1 fixed idle floats", int'({rdyOe, dataOe}), 0);
    modeSel = 2'b10;
    #1;
    chk(rdyOe === 1'b1 && rdyOut === 1'b1 && dataOe === 1'b0, "R1 variable idle ready high",
        int'({rdyOe, rdyOut, dataOe}), 6);
    modeSel = 2'b00;
    @(negedge clk);

    // Fixed, active-high write: every reset value
    for (int a = 0; a < 64; a++) fixedAcc(1'b0, 6'(a), 8'h00, 1'b0, 1'b0, 1'b0, 6'd0, 8'h00, "R3");

    // Fixed back-to-back writes, then back-to-back reads (R5, R4)
    for (int i = 0; i < 16; i++)
      fixedAcc(1'b1, 6'(i * 4 + 1), 8'(i * 17 + 3), i > 0, i < 15,
               1'b1, 6'((i + 1) * 4 + 1), 8'((i + 1) * 17 + 3), "R5");
    @(negedge clk);
    for (int i = 0; i < 16; i++)
      fixedAcc(1'b0, 6'(i * 4 + 1), 8'h00, i > 0, i < 15,
               1'b0, 6'((i + 1) * 4 + 1), 8'h00, "R4");
    @(negedge clk);

    // Fixed, active-low write enable (R9)
    modeSel = 2'b01;
    @(negedge clk);
    for (int i = 0; i < 8; i++) fixedAcc(1'b1, 6'(i * 8 + 2), 8'(200 - i * 9), 1'b0, 1'b0, 1'b0, 6'd0, 8'h00, "R9");
    for (int i = 0; i < 8; i++) fixedAcc(1'b0, 6'(i * 8 + 2), 8'h00, 1'b0, 1'b0, 1'b0, 6'd0, 8'h00, "R9");

    // Variable, active-low write enable
    modeSel = 2'b11;
    @(negedge clk);
    for (int a = 0; a < 16; a++) varAcc(1'b0, 6'(a), 8'h00, 5 + (a % 4), "R3");
    for (int i = 0; i < 8; i++) varAcc(1'b1, 6'(i * 7 + 4), 8'(i * 5 + 99), 4 + (i % 3), "R10");
    for (int i = 0; i < 8; i++) varAcc(1'b0, 6'(i * 7 + 4), 8'h00, 5, "R10");
    for (int l = 0; l < 4; l++) varAcc(1'b1, 6'(60 + l), 8'hA5, l, "R11");
    for (int l = 0; l < 4; l++) varAcc(1'b0, 6'(60 + l), 8'h00, 5, "R11");

    // Variable, active-high write enable (R9)
    modeSel = 2'b10;
    @(negedge clk);
    for (int i = 0; i < 8; i++) varAcc(1'b1, 6'(i + 3), 8'(i * 29 + 1), 5, "R9");
    for (int i = 0; i < 8; i++) varAcc(1'b0, 6'(i + 3), 8'h00, 6, "R9");

    // R8: one-edge recovery pulse delays the next start by one clock
    csN = 1'b0; addrIn = 6'd40; dirIn = dirFor(1'b0);
    @(posedge clk);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 6) csN = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    csN = 1'b0;
    #4;
    chk(rdyOut === 1'b1 && dataOe === 1'b0, "R8 recovery clock quiet", int'({rdyOut, dataOe}), 2);
    @(posedge clk);
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      #4;
      chk(dataOe === (c == 6), "R8 start delayed by recovery", int'(dataOe), int'(c == 6));
      if (c == 6) chk(dataOut === expMem[40], "R8 read data after recovery", int'(dataOut), int'(expMem[40]));
      @(posedge clk);
    end
    @(negedge clk);
    csN = 1'b1;
    repeat (2) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule